// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block keeps the interrupt status of a small Ethernet controller and combines it into one active-low interrupt line. It has three flag sources, and each one behaves in its own way. The DMA-done flag is set by an edge and stays set. The link-change flag copies a flag on the PHY side that has its own pair of enables. The receive-pending flag follows a saturating count of pending packets.

The host controls the block through a small write port. Address 0 holds the source enables and the global enable. Address 1 takes a clear mask for the flag vector. Address 2 holds the two PHY-side enables. The host can read the three flags and the packet count directly at any time, so polling works whether or not interrupts are enabled.

State machines: DMA flag `DMA_IDLE` -> `DMA_DONE` on a busy fall, and `DMA_DONE` -> `DMA_IDLE` on a clear write with no fall in the same cycle. PHY flag `LNK_IDLE` -> `LNK_SEEN` on a link event, and `LNK_SEEN` -> `LNK_IDLE` on a status read with no event in the same cycle. Output driver `IRQ_RELEASED` -> `IRQ_DRIVEN` when any source qualifies, and `IRQ_DRIVEN` -> `IRQ_RELEASED` when none does.

Top module: `nic_irq_aggregator`

## Requirements
- R1: `flags[0]` (DMA done) becomes 1 one cycle after `dma_busy` is sampled falling from 1 to 0. A fall caused by the host cancelling the operation counts the same as a normal finish.
- R2: The DMA flag stays 1 until a write to address 1 with `wr_data[0]`=1, or a reset. A mask bit of 0 leaves it set. If a busy fall arrives in the same cycle as the clear, the flag stays 1.
- R3: `irq_n` is registered. It is 0 in the cycle after some flag is 1 while that flag's enable (address 0, bits 0/1/2 for DMA/link/receive) and the global enable (address 0, bit 7) are all 1. It returns to 1 one cycle after no source qualifies.
- R4: The flags can still be read on `flags` when their enables or the global enable are 0.
- R5: The PHY-side link flag records every `phy_link_event`. `flags[1]` equals that flag AND both PHY enables (address 2, bit 0 link-change enable, bit 1 PHY global enable). With either PHY enable at 0, `flags[1]` stays 0.
- R6: A `phy_stat_rd` pulse clears the PHY-side flag and therefore `flags[1]`. An event in the same cycle as the read wins, and the flag is set.
- R7: A link interrupt also needs link source enable bit 1 at address 0. With that bit at 0, `irq_n` stays 1 even while `flags[1]` is 1.
- R8: `flags[2]` (receive pending) is 1 exactly when `pkt_count` is non-zero. It clears by itself when the count is decremented to 0.
- R9: `pkt_count` counts up on `pkt_inc` and down on `pkt_dec`. It holds at 255 and at 0 instead of wrapping. An increment and a decrement in the same cycle leave it unchanged.
- R10: After reset, `flags`=0, `pkt_count`=0, `irq_n`=1 and all enables are 0. Writing 1 to clear-mask bits 1 or 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | 0 enables, 1 clear mask, 2 PHY enables |
| wr_data | input | 8 | Write data |
| dma_busy | input | 1 | DMA engine busy bit |
| phy_link_event | input | 1 | PHY link status change pulse |
| phy_stat_rd | input | 1 | PHY interrupt status read strobe |
| pkt_inc | input | 1 | Packet stored strobe |
| pkt_dec | input | 1 | Packet released strobe |
| flags | output | 3 | bit0 DMA done, bit1 link change, bit2 receive pending |
| pkt_count | output | 8 | Pending packet count |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a busy fall that lands in the same cycle as a DMA clear write. The other is a link event that coincides with a PHY status read. The stimulus drives both inputs on the same falling clock edge, so the same rising edge samples them together. A second hard case is a PHY flag that was recorded while the PHY enables were off and then shows up when they are turned on. The bench sets up that hidden state, clears it with a read, and then shows through `flags` that turning the enables on reveals nothing.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int NUM_SRC  = 3;
    localparam int SRC_DMA  = 0;
    localparam int SRC_LINK = 1;
    localparam int SRC_RX   = 2;
    localparam int GIE_BIT  = 7;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PHYEN  = 2'd2;

    localparam int PHY_LNK_EN = 0;
    localparam int PHY_GBL_EN = 1;

    typedef enum logic { DMA_IDLE, DMA_DONE } dma_state_t;
    typedef enum logic { LNK_IDLE, LNK_SEEN } lnk_state_t;
    typedef enum logic { IRQ_RELEASED, IRQ_DRIVEN } irq_state_t;
endpackage

// File: rtl/nic_dma_flag.sv
module nic_dma_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_busy,
    input  logic clr_req,
    output logic flag
);
    import nic_irq_pkg::*;

    dma_state_t state_q, state_d;
    logic       busy_q;
    logic       busy_fall;

    assign busy_fall = busy_q & ~dma_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            state_q <= DMA_IDLE;
        end else begin
            busy_q  <= dma_busy;
            state_q <= state_d;
        end
    end

    // a fall outranks a clear arriving in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE: if (busy_fall)             state_d = DMA_DONE;
            DMA_DONE: if (clr_req && !busy_fall) state_d = DMA_IDLE;
        endcase
    end

    always_comb flag = (state_q == DMA_DONE);
endmodule

// File: rtl/nic_link_flag.sv
module nic_link_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic link_event,
    input  logic stat_rd,
    input  logic lnk_en,
    input  logic gbl_en,
    output logic flag
);
    import nic_irq_pkg::*;

    lnk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LNK_IDLE;
        else        state_q <= state_d;
    end

    // an event outranks a status read in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE: if (link_event)             state_d = LNK_SEEN;
            LNK_SEEN: if (stat_rd && !link_event) state_d = LNK_IDLE;
        endcase
    end

    always_comb flag = (state_q == LNK_SEEN) && lnk_en && gbl_en;
endmodule

// File: rtl/nic_rx_pending.sv
module nic_rx_pending #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc && !dec) begin
            if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
        end else if (dec && !inc) begin
            if (count_q != '0) count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;
    assign flag  = (count_q != '0);
endmodule

// File: rtl/nic_irq_drive.sv
module nic_irq_drive #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] src_en,
    input  logic         gbl_en,
    output logic         irq_n
);
    import nic_irq_pkg::*;

    irq_state_t state_q, state_d;
    logic       any_qual;

    assign any_qual = gbl_en && |(flags & src_en);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_RELEASED: if (any_qual)  state_d = IRQ_DRIVEN;
            IRQ_DRIVEN:   if (!any_qual) state_d = IRQ_RELEASED;
        endcase
    end

    always_comb irq_n = (state_q != IRQ_DRIVEN);
endmodule

// File: rtl/nic_irq_aggregator.sv
module nic_irq_aggregator #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             dma_busy,
    input  logic             phy_link_event,
    input  logic             phy_stat_rd,
    input  logic             pkt_inc,
    input  logic             pkt_dec,
    output logic [2:0]       flags,
    output logic [CNT_W-1:0] pkt_count,
    output logic             irq_n
);
    import nic_irq_pkg::*;

    logic [NUM_SRC-1:0] src_en_q;
    logic               gie_q;
    logic [1:0]         phy_en_q;
    logic               dma_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en_q <= '0;
            gie_q    <= 1'b0;
            phy_en_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_ENABLE) begin
                src_en_q <= wr_data[NUM_SRC-1:0];
                gie_q    <= wr_data[GIE_BIT];
            end
            if (wr_addr == ADDR_PHYEN) phy_en_q <= wr_data[1:0];
        end
    end

    assign dma_clr = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[SRC_DMA];

    nic_dma_flag u_dma (
        .clk(clk), .rst_n(rst_n), .dma_busy(dma_busy),
        .clr_req(dma_clr), .flag(flags[SRC_DMA])
    );

    nic_link_flag u_link (
        .clk(clk), .rst_n(rst_n), .link_event(phy_link_event),
        .stat_rd(phy_stat_rd), .lnk_en(phy_en_q[PHY_LNK_EN]),
        .gbl_en(phy_en_q[PHY_GBL_EN]), .flag(flags[SRC_LINK])
    );

    nic_rx_pending #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .inc(pkt_inc), .dec(pkt_dec),
        .count(pkt_count), .flag(flags[SRC_RX])
    );

    nic_irq_drive #(.N(NUM_SRC)) u_drv (
        .clk(clk), .rst_n(rst_n), .flags(flags),
        .src_en(src_en_q), .gbl_en(gie_q), .irq_n(irq_n)
    );
endmodule

// File: rtl/nic_irq_aggregator_chk.sv
module nic_irq_aggregator_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             dma_busy,
    input logic             phy_link_event,
    input logic             phy_stat_rd,
    input logic             pkt_inc,
    input logic             pkt_dec,
    input logic [2:0]       flags,
    input logic [CNT_W-1:0] pkt_count,
    input logic             irq_n,
    input logic [2:0]       src_en_q,
    input logic             gie_q,
    input logic [1:0]       phy_en_q
);
    logic qual;
    assign qual = gie_q && |(flags & src_en_q);

    assert_dma_fall_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_busy) |=> flags[0]);

    assert_dma_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && !(wr_en && wr_addr == 2'd1 && wr_data[0]) |=> flags[0]);

    assert_irq_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(qual));

    assert_link_needs_phy_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] |-> phy_en_q == 2'b11);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stat_rd && !phy_link_event |=> !flags[1]);

    assert_rx_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags[2] == (pkt_count != '0));

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&pkt_count) && pkt_inc && !pkt_dec |=> (&pkt_count));

    assert_count_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_count == '0 && pkt_dec && !pkt_inc |=> pkt_count == '0);
endmodule

bind nic_irq_aggregator nic_irq_aggregator_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/nic_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module nic_irq_aggregator_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       dma_busy = 1'b0, phy_link_event = 1'b0, phy_stat_rd = 1'b0;
    logic       pkt_inc = 1'b0, pkt_dec = 1'b0;
    logic [2:0] flags;
    logic [7:0] pkt_count;
    logic       irq_n;

    always #2 clk = ~clk;

    nic_irq_aggregator dut_i (.*);

    typedef struct packed {
        logic [2:0] fl;
        logic       irq;
        logic [7:0] cnt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  push_ev;
    int    total = 0, bad = 0;
    bit    finished = 0;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic [2:0] fl, logic irq, logic [7:0] cnt);
        exp_t e;
        e.fl = fl; e.irq = irq; e.cnt = cnt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> push_ev;
        #0;
    endtask

    task automatic host_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_event();
        phy_link_event = 1'b1; step(); phy_link_event = 1'b0;
    endtask

    task automatic pulse_read();
        phy_stat_rd = 1'b1; step(); phy_stat_rd = 1'b0;
    endtask

    // monitor: pop expected items and compare with the live outputs
    initial begin
        forever begin
            @(push_ev);
            while (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (flags !== e.fl || irq_n !== e.irq || pkt_count !== e.cnt) begin
                    bad++;
                    $display("FAIL %s: flags=%b irq_n=%b cnt=%0d expected flags=%b irq_n=%b cnt=%0d",
                             t, flags, irq_n, pkt_count, e.fl, e.irq, e.cnt);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        expect_out("R10 reset", 3'b000, 1'b1, 8'd0);
        host_wr(2'd0, 8'h87);

        // R1 normal completion
        dma_busy = 1'b1; step();
        dma_busy = 1'b0; step();
        expect_out("R1 fall sets flag", 3'b001, 1'b1, 8'd0);
        step();
        expect_out("R3 irq asserts", 3'b001, 1'b0, 8'd0);
        step(); step();
        expect_out("R2 sticky", 3'b001, 1'b0, 8'd0);
        host_wr(2'd1, 8'h06);
        expect_out("R10 other mask bits no effect", 3'b001, 1'b0, 8'd0);
        host_wr(2'd1, 8'h01);
        expect_out("R2 clear", 3'b000, 1'b0, 8'd0);
        step();
        expect_out("R3 irq releases", 3'b000, 1'b1, 8'd0);

        // R1/R2 cancel collides with clear
        dma_busy = 1'b1; step();
        dma_busy = 1'b0; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h01;
        step();
        wr_en = 1'b0;
        expect_out("R2 fall wins over clear", 3'b001, 1'b1, 8'd0);
        step();
        expect_out("R1 cancel raises irq", 3'b001, 1'b0, 8'd0);

        // R4 global disable keeps flag pollable
        host_wr(2'd0, 8'h07);
        expect_out("R3 lag after disable", 3'b001, 1'b0, 8'd0);
        step();
        expect_out("R4 poll with global off", 3'b001, 1'b1, 8'd0);
        host_wr(2'd1, 8'h01);
        host_wr(2'd0, 8'h87);
        expect_out("R2 cleared again", 3'b000, 1'b1, 8'd0);

        // R5 link flag gated by PHY enables
        pulse_event();
        expect_out("R5 gated off", 3'b000, 1'b1, 8'd0);
        host_wr(2'd2, 8'h03);
        expect_out("R5 mirrors after enable", 3'b010, 1'b1, 8'd0);
        step();
        expect_out("R7 link irq", 3'b010, 1'b0, 8'd0);
        host_wr(2'd0, 8'h85);
        step();
        expect_out("R7 link source disabled", 3'b010, 1'b1, 8'd0);
        host_wr(2'd0, 8'h87);
        step();
        expect_out("R7 link re-enabled", 3'b010, 1'b0, 8'd0);
        pulse_read();
        expect_out("R6 read clears", 3'b000, 1'b0, 8'd0);
        step();
        expect_out("R6 irq releases", 3'b000, 1'b1, 8'd0);
        host_wr(2'd2, 8'h01);
        pulse_event();
        expect_out("R5 one PHY enable", 3'b000, 1'b1, 8'd0);
        pulse_read();
        host_wr(2'd2, 8'h03);
        expect_out("R6 hidden flag cleared", 3'b000, 1'b1, 8'd0);
        phy_link_event = 1'b1; phy_stat_rd = 1'b1; step();
        phy_link_event = 1'b0; phy_stat_rd = 1'b0;
        expect_out("R6 event wins over read", 3'b010, 1'b1, 8'd0);
        pulse_read();
        expect_out("R6 second read", 3'b000, 1'b0, 8'd0);
        step();

        // R8/R9 receive pending
        pkt_inc = 1'b1; step(); pkt_inc = 1'b0;
        expect_out("R8 flag with count 1", 3'b100, 1'b1, 8'd1);
        step();
        expect_out("R3 rx irq", 3'b100, 1'b0, 8'd1);
        pkt_inc = 1'b1; pkt_dec = 1'b1; step(); pkt_inc = 1'b0; pkt_dec = 1'b0;
        expect_out("R9 inc and dec hold", 3'b100, 1'b0, 8'd1);
        pkt_dec = 1'b1; step();
        expect_out("R8 auto clear at zero", 3'b000, 1'b0, 8'd0);
        step();
        expect_out("R9 floor at zero", 3'b000, 1'b1, 8'd0);
        pkt_dec = 1'b0;
        pkt_inc = 1'b1;
        for (int i = 0; i < 256; i++) step();
        expect_out("R9 reaches max", 3'b100, 1'b0, 8'd255);
        step();
        expect_out("R9 saturates at max", 3'b100, 1'b0, 8'd255);
        pkt_inc = 1'b0; pkt_dec = 1'b1; step(); pkt_dec = 1'b0;
        expect_out("R9 down from max", 3'b100, 1'b0, 8'd254);

        step(); step();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule